// File: doc/BRIEF.md
# Auto-Increment Banked Storage Port

This block lets a CPU reach a large external byte store through a handful of narrow I/O ports. The CPU writes the wanted address as three bytes (low, middle and a short top field) and then moves data through a single data port. After every data access the low address byte steps forward by one, so a CPU can stream up to 256 consecutive bytes without reloading the address. The middle and top bytes never change on their own.

The store is split in two equal halves by the top address bit. The lower half is writable RAM and the upper half is read-only ROM. A control port opens the unit and can set write protection. A status read at the same offset reports whether the unit is installed and echoes the open and protect settings. The storage arrays sit outside the block: it drives an address, a write strobe and write data, and takes read data back combinationally.

Reads return their byte on `io_rdata` one clock after the read strobe. The value then holds until the next read of a decoded port.

Top module: `bank_store_port`

## Requirements
- R1: After a synchronous reset the address is zero, the unit is closed and unprotected, and `io_rdata` is 0x00.
- R2: A write to offset 0 loads address bits 7:0 and a write to offset 1 loads bits 15:8. A write to offset 2 loads only the low `ADDR_W-16` data bits into the top address bits, and the rest of that byte is dropped.
- R3: A data read at offset 3 while the unit is open returns the stored byte at the current address one cycle later. It then adds one to address bits 7:0, wrapping 0xFF to 0x00 with no carry into bits 15:8 or the top field.
- R4: A data write at offset 3 while the unit is open, unprotected and addressing the RAM half (top address bit 0) stores the byte at the current address. It then adds one to the low address byte in the same way as R3.
- R5: A data write is dropped when the unit is closed, when protection is set, or when the top address bit is 1 (ROM half). The low address byte still advances in every one of these cases.
- R6: A data read while the unit is closed returns 0xFF and leaves the address unchanged.
- R7: A write to offset 4 sets "open" from data bit 1 and "protect" from data bit 0. A read of offset 4 returns bit 7 = 0 when `unit_present` is 1 (1 when it is 0), bit 1 = open, bit 0 = protect, and bits 6:2 = 0.
- R8: When read and write strobes are both high in one cycle, only the write is performed. `io_rdata` holds its old value and the address advances once.
- R9: Reads of offsets 0, 1, 2, 5, 6 and 7 return 0x00. Writes to offsets 5 to 7 change neither the address nor the control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_sel | input | 3 | Port offset within the block |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | CPU write data |
| io_rdata | output | 8 | Registered read data |
| unit_present | input | 1 | High when the storage unit is fitted |
| mem_addr | output | ADDR_W | Address to the storage arrays |
| mem_wdata | output | 8 | Write data to the RAM array |
| mem_we | output | 1 | RAM write enable, taken at the clock edge |
| mem_rdata | input | 8 | Combinational read data from the arrays |

## Verification
The embedded properties check on every cycle that:
- the low address byte steps by one, wrapping at 0xFF, after each counted access;
- the middle and top address fields never move on an increment;
- a performed write is always followed by an increment;
- a closed read yields 0xFF with the address frozen;
- the unused status bits stay at zero.

Only the bench scenarios can show that the right bytes land in the right places. It sweeps whole pages in several banks of the RAM half and reads them back. It checks that protected, closed and ROM-half writes leave stored data intact, and that the top-byte masking and simultaneous strobes behave as specified.

// File: rtl/bsp_pkg.sv
// Package: shared offsets and types for the banked storage port.
// Assumes a 3-bit port offset and byte-wide CPU data.
package bsp_pkg;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NUM_PORTS = 5;

    typedef enum logic [SEL_W-1:0] {
        PORT_ADR_LO  = 3'd0,
        PORT_ADR_MID = 3'd1,
        PORT_ADR_TOP = 3'd2,
        PORT_DATA    = 3'd3,
        PORT_CTRL    = 3'd4
    } port_e;

    typedef struct packed {
        logic open;
        logic wprot;
    } ctrl_t;
endpackage

// File: rtl/bsp_decode.sv
// Module: bsp_decode
// Turns the CPU strobes and offset into one-hot access pulses.
// Assumes one strobe per access; a write strobe masks a read strobe.
module bsp_decode
    import bsp_pkg::*;
(
    input  logic [SEL_W-1:0]     io_sel_i,
    input  logic                 io_wr_i,
    input  logic                 io_rd_i,
    output logic [NUM_PORTS-1:0] wr_hot_o,
    output logic                 rd_data_o,
    output logic                 rd_stat_o,
    output logic                 rd_other_o
);
    logic rd_ok;

    // One write pulse per decoded port offset
    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_wr
        assign wr_hot_o[gi] = io_wr_i && (io_sel_i == SEL_W'(gi));
    end

    // Read is honoured only when no write shares the cycle
    assign rd_ok      = io_rd_i && !io_wr_i;
    assign rd_data_o  = rd_ok && (io_sel_i == PORT_DATA);
    assign rd_stat_o  = rd_ok && (io_sel_i == PORT_CTRL);
    assign rd_other_o = rd_ok && (io_sel_i != PORT_DATA) && (io_sel_i != PORT_CTRL);
endmodule

// File: rtl/bsp_addr_reg.sv
// Module: bsp_addr_reg
// Holds the storage address as low, middle and top fields.
// Only the low field counts; it wraps without carrying.
// Assumes ADDR_W > 16 and ADDR_W <= 24.
module bsp_addr_reg #(
    parameter int unsigned ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo_i,
    input  logic              wr_mid_i,
    input  logic              wr_top_i,
    input  logic [7:0]        wdata_i,
    input  logic              bump_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int unsigned TOP_W = ADDR_W - 16;

    logic [7:0]       lo_q;
    logic [7:0]       mid_q;
    logic [TOP_W-1:0] top_q;

    // Low byte: load from CPU, else step after a data access
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_q <= '0;
        else if (wr_lo_i) lo_q <= wdata_i;
        else if (bump_i)  lo_q <= lo_q + 8'd1;
    end

    // Middle byte: loaded only by the CPU
    always_ff @(posedge clk) begin
        if (!rst_n)        mid_q <= '0;
        else if (wr_mid_i) mid_q <= wdata_i;
    end

    // Top field: keeps only its own width of the written byte
    always_ff @(posedge clk) begin
        if (!rst_n)        top_q <= '0;
        else if (wr_top_i) top_q <= wdata_i[TOP_W-1:0];
    end

    assign addr_o = {top_q, mid_q, lo_q};

    AST_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_i && !wr_lo_i) |=> (lo_q == 8'($past(lo_q) + 8'd1))); // R3
    AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_i && !wr_mid_i && !wr_top_i) |=> ($stable(mid_q) && $stable(top_q))); // R3
    AST_LOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_i && !wr_lo_i && lo_q == 8'hFF) |=> (lo_q == 8'h00)); // R3
endmodule

// File: rtl/bsp_ctrl_reg.sv
// Module: bsp_ctrl_reg
// Stores the open and write-protect settings.
// Assumes only data bits 1:0 of a control write are meaningful.
module bsp_ctrl_reg
    import bsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl_i,
    input  logic [1:0] wdata_i,
    output ctrl_t      ctrl_o
);
    ctrl_t ctrl_q;

    // Control settings: closed and unprotected out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl_i) begin
            ctrl_q.open  <= wdata_i[1];
            ctrl_q.wprot <= wdata_i[0];
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/bsp_data_path.sv
// Module: bsp_data_path
// Gates RAM writes, decides when the address counts, and
// registers the read result.
// Assumes mem_rdata_i is valid combinationally for the current address.
module bsp_data_path
    import bsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_data_i,
    input  logic       rd_data_i,
    input  logic       rd_stat_i,
    input  logic       rd_other_i,
    input  ctrl_t      ctrl_i,
    input  logic       present_i,
    input  logic       rom_half_i,
    input  logic [7:0] mem_rdata_i,
    output logic       mem_we_o,
    output logic       bump_o,
    output logic [7:0] rdata_o
);
    logic [7:0] rdata_q;
    logic [7:0] status_w;

    // Write reaches the array only when open, unprotected and in RAM
    assign mem_we_o = wr_data_i && ctrl_i.open && !ctrl_i.wprot && !rom_half_i;

    // Every data write counts; a data read counts only when open
    assign bump_o = wr_data_i || (rd_data_i && ctrl_i.open);

    // Status byte: absent flag on top, settings in the low bits
    assign status_w = {!present_i, 5'b0, ctrl_i.open, ctrl_i.wprot};

    // Read result register, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (rd_data_i)  rdata_q <= ctrl_i.open ? mem_rdata_i : 8'hFF;
        else if (rd_stat_i)  rdata_q <= status_w;
        else if (rd_other_i) rdata_q <= 8'h00;
    end

    assign rdata_o = rdata_q;

    AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat_i |=> (rdata_q[6:2] == 5'b0)); // R7
endmodule

// File: rtl/bank_store_port.sv
// Module: bank_store_port
// Top level of the auto-increment banked storage port. It joins
// decode, address, control and data path blocks.
// Assumes external arrays read combinationally and write on the edge.
module bank_store_port
    import bsp_pkg::*;
#(
    parameter int unsigned ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        io_sel,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              unit_present,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata
);
    localparam int unsigned MSB = ADDR_W - 1;

    logic [NUM_PORTS-1:0] wr_hot;
    logic                 rd_data;
    logic                 rd_stat;
    logic                 rd_other;
    logic                 bump;
    ctrl_t                ctrl;

    bsp_decode u_decode (
        .io_sel_i   (io_sel),
        .io_wr_i    (io_wr),
        .io_rd_i    (io_rd),
        .wr_hot_o   (wr_hot),
        .rd_data_o  (rd_data),
        .rd_stat_o  (rd_stat),
        .rd_other_o (rd_other)
    );

    bsp_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo_i  (wr_hot[PORT_ADR_LO]),
        .wr_mid_i (wr_hot[PORT_ADR_MID]),
        .wr_top_i (wr_hot[PORT_ADR_TOP]),
        .wdata_i  (io_wdata),
        .bump_i   (bump),
        .addr_o   (mem_addr)
    );

    bsp_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_hot[PORT_CTRL]),
        .wdata_i   (io_wdata[1:0]),
        .ctrl_o    (ctrl)
    );

    bsp_data_path u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_data_i   (wr_hot[PORT_DATA]),
        .rd_data_i   (rd_data),
        .rd_stat_i   (rd_stat),
        .rd_other_i  (rd_other),
        .ctrl_i      (ctrl),
        .present_i   (unit_present),
        .rom_half_i  (mem_addr[MSB]),
        .mem_rdata_i (mem_rdata),
        .mem_we_o    (mem_we),
        .bump_o      (bump),
        .rdata_o     (io_rdata)
    );

    assign mem_wdata = io_wdata;

    AST_WE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr[7:0] == 8'($past(mem_addr[7:0]) + 8'd1))); // R4
    AST_CLOSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !ctrl.open) |=> (io_rdata == 8'hFF && $stable(mem_addr))); // R6
    AST_PROT_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_sel == PORT_DATA && mem_addr[MSB]) |-> !mem_we); // R5
endmodule

// File: tb/sim_bank_store_port.sv
module sim_bank_store_port;
    localparam int unsigned AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    io_sel = '0;
    logic          io_wr = 1'b0;
    logic          io_rd = 1'b0;
    logic [7:0]    io_wdata = '0;
    logic [7:0]    io_rdata;
    logic          unit_present = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic [7:0]    mem_rdata;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    logic [7:0] ram [0:4095];

    always #2.5 clk = ~clk;

    bank_store_port #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .unit_present(unit_present),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [11:0] ram_idx(logic [AW-1:0] a);
        return {a[17:16], a[9:8], a[7:0]};
    endfunction

    function automatic logic [7:0] rom_byte(logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] pat(logic [AW-1:0] a);
        return 8'(a[7:0] * 5 + a[15:8] + a[18:16] * 29 + 3);
    endfunction

    // Storage model: ROM computed, RAM small and indexed
    always_comb mem_rdata = mem_addr[AW-1] ? rom_byte(mem_addr) : ram[ram_idx(mem_addr)];
    always @(posedge clk) if (mem_we) ram[ram_idx(mem_addr)] <= mem_wdata;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic acc(logic wr, logic rd, logic [2:0] sel, logic [7:0] d);
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_sel = sel; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] d);
        acc(1'b1, 1'b0, sel, d);
    endtask

    task automatic rd(logic [2:0] sel);
        acc(1'b0, 1'b1, sel, 8'h00);
    endtask

    task automatic set_addr(logic [7:0] t, logic [7:0] m, logic [7:0] l);
        wr(3'd2, t); wr(3'd1, m); wr(3'd0, l);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        summary();
    end

    initial begin
        logic [AW-1:0] a;
        logic [7:0] keep;
        logic [7:0] tops [0:3];
        logic [7:0] mids [0:2];
        for (int i = 0; i < 4096; i++) ram[i] = 8'h00;
        tops[0] = 8'h00; tops[1] = 8'h01; tops[2] = 8'h02; tops[3] = 8'h03;
        mids[0] = 8'h00; mids[1] = 8'h5A; mids[2] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 addr", 32'(mem_addr), 32'h0);
        chk("R1 rdata", 32'(io_rdata), 32'h00);
        rd(3'd4);
        chk("R1 R7 status", 32'(io_rdata), 32'h00);
        unit_present = 1'b0;
        rd(3'd4);
        chk("R7 absent", 32'(io_rdata), 32'h80);
        unit_present = 1'b1;

        // R6 closed read
        set_addr(8'h01, 8'h22, 8'h40);
        chk("R2 addr load", 32'(mem_addr), 32'h12240);
        rd(3'd3);
        chk("R6 closed data", 32'(io_rdata), 32'hFF);
        chk("R6 no step", 32'(mem_addr), 32'h12240);

        // R7 open
        wr(3'd4, 8'hFE);
        rd(3'd4);
        chk("R7 open", 32'(io_rdata), 32'h02);

        // R3 R4 page sweeps with wrap
        for (int t = 0; t < 4; t++) begin
            for (int m = 0; m < 3; m++) begin
                set_addr(tops[t], mids[m], 8'h00);
                for (int l = 0; l < 256; l++) begin
                    a = {tops[t][2:0], mids[m], 8'(l)};
                    wr(3'd3, pat(a));
                end
                chk("R4 R3 wrap no carry", 32'(mem_addr), 32'({tops[t][2:0], mids[m], 8'h00}));
                wr(3'd0, 8'h00);
                for (int l = 0; l < 256; l++) begin
                    a = {tops[t][2:0], mids[m], 8'(l)};
                    rd(3'd3);
                    chk("R3 R4 readback", 32'(io_rdata), 32'(pat(a)));
                end
                chk("R3 read wrap", 32'(mem_addr), 32'({tops[t][2:0], mids[m], 8'h00}));
            end
        end

        // R2 top masking
        wr(3'd2, 8'hFD);
        chk("R2 top mask", 32'(mem_addr[18:16]), 32'h5);

        // R5 ROM half write dropped
        set_addr(8'h04, 8'h12, 8'h30);
        wr(3'd3, 8'h00);
        chk("R5 rom step", 32'(mem_addr), 32'h41231);
        wr(3'd0, 8'h30);
        rd(3'd3);
        chk("R5 rom kept", 32'(io_rdata), 32'(rom_byte(19'h41230)));

        // R5 protected write dropped
        set_addr(8'h00, 8'h00, 8'h20);
        wr(3'd4, 8'h03);
        rd(3'd4);
        chk("R7 protect", 32'(io_rdata), 32'h03);
        wr(3'd3, 8'hEE);
        chk("R5 prot step", 32'(mem_addr), 32'h00021);
        wr(3'd4, 8'h02);
        wr(3'd0, 8'h20);
        rd(3'd3);
        chk("R5 prot kept", 32'(io_rdata), 32'(pat(19'h00020)));

        // R5 closed write dropped
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h20);
        wr(3'd3, 8'hEE);
        chk("R5 closed step", 32'(mem_addr), 32'h00021);
        wr(3'd4, 8'h02);
        wr(3'd0, 8'h20);
        rd(3'd3);
        chk("R5 closed kept", 32'(io_rdata), 32'(pat(19'h00020)));

        // R8 simultaneous strobes
        wr(3'd0, 8'h10);
        rd(3'd3);
        keep = io_rdata;
        chk("R8 pre read", 32'(keep), 32'(pat(19'h00010)));
        acc(1'b1, 1'b1, 3'd3, 8'h77);
        chk("R8 rdata hold", 32'(io_rdata), 32'(keep));
        chk("R8 single step", 32'(mem_addr), 32'h00012);
        wr(3'd0, 8'h11);
        rd(3'd3);
        chk("R8 write done", 32'(io_rdata), 32'h77);

        // R9 unused offsets
        for (int s = 0; s < 8; s++) begin
            if (s == 3 || s == 4) continue;
            rd(3'(s));
            chk("R9 read zero", 32'(io_rdata), 32'h00);
        end
        a = mem_addr;
        for (int s = 5; s < 8; s++) wr(3'(s), 8'hFF);
        chk("R9 addr kept", 32'(mem_addr), 32'(a));
        rd(3'd4);
        chk("R9 ctrl kept", 32'(io_rdata), 32'h02);

        // R1 reset mid-run
        set_addr(8'h02, 8'h33, 8'h44);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        chk("R1 re-reset addr", 32'(mem_addr), 32'h0);
        chk("R1 re-reset rdata", 32'(io_rdata), 32'h00);
        rd(3'd4);
        chk("R1 re-reset ctrl", 32'(io_rdata), 32'h00);

        summary();
    end
endmodule